// File: doc/BRIEF.md
# Decimal-mode add/subtract unit

This is a purely combinational two-digit BCD adder and subtractor. It reproduces, bit for bit, how a classic 8-bit microprocessor ALU behaves when its decimal flag is set. It takes two operand bytes, a carry-in and an add/subtract select. It returns the corrected result byte and the negative, overflow, zero and carry flags. It is meant to sit beside a binary ALU inside a processor core, and the decoder selects it when decimal mode is active.

Three processor generations treat decimal arithmetic slightly differently, and a `VARIANT` parameter chooses among them. The differences lie in two places: where each flag is taken from, and when the subtraction applies its low-digit correction. Every one of the 65536 operand pairs gives a defined result, including bytes whose nibbles are not valid BCD. Those inputs must match the legacy behaviour exactly, because existing software relies on it.

Top module: `bcd_alu`

## Requirements
- R1: On addition, the low digit is `a[3:0] + b[3:0] + carry_in`. When that sum is 10 or more, 6 is added and only the low 4 bits are kept, and 0x10 is added into the high-digit stage. For valid BCD operands, the result is therefore the decimal sum modulo 100.
- R2: On addition, the high stage adds `{a[7:4], adjusted low digit}`, `b & 0xF0` and the low-digit carry. When this stage carries out of bit 7 or reaches 0xA0 or more, 0x60 is added (modulo 256) and `flag_c` is 1. Otherwise `flag_c` is 0.
- R3: With `VARIANT` 0 (original NMOS part) on addition, `flag_n` and `flag_v` come from the high-stage byte before the 0x60 correction. `flag_z` is 1 exactly when the 8-bit binary sum `a + b + carry_in` is zero.
- R4: With `VARIANT` 1 (CMOS revision) or 2 (16-bit successor in 8-bit mode) on addition, `flag_n` is bit 7 of `result` and `flag_z` is 1 exactly when `result` is zero. On addition, for every variant, `flag_v` is 1 when `a[7] == b[7]` and bit 7 of the uncorrected high-stage byte differs from `a[7]`.
- R5: With `VARIANT` 0 or 2 on subtraction, the low digit is `a[3:0] - b[3:0] - !carry_in`. On a borrow, a further 6 is subtracted, the value is masked to 4 bits, and `(b & 0xF0) + 0x10` is subtracted from the combined byte. Otherwise only `b & 0xF0` is subtracted. When the high stage borrows, a further 0x60 is subtracted.
- R6: With `VARIANT` 1 on subtraction, the low digit is not adjusted by 6 at first. After the high stage and its 0x60 correction, 6 is subtracted from the whole byte when the low-digit step borrowed.
- R7: With `VARIANT` 0 on subtraction, all four flags equal those of the binary subtraction `a - b - !carry_in`. For that subtraction, C is 1 when there is no borrow, and V is 1 when `a[7] != b[7]` and bit 7 of the difference differs from `a[7]`.
- R8: With `VARIANT` 1 or 2 on subtraction, `flag_n` and `flag_z` come from `result`, while `flag_v` and `flag_c` are those of the binary subtraction.
- R9: `carry_in` = 1 means no borrow on subtraction (`do_sub` = 1) and an added one on addition (`do_sub` = 0). For valid BCD operands, the subtraction result is `(a - b - !carry_in)` modulo 100 in decimal.
- R10: Every output is a defined 0/1 value for every combination of operands, carry-in, select and variant, including non-BCD nibbles. A `VARIANT` outside 0 to 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand (minuend on subtraction) |
| opnd_b | input | 8 | Second operand (subtrahend on subtraction) |
| carry_in | input | 1 | Carry in; 1 = no borrow on subtraction |
| do_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| result | output | 8 | Decimal-corrected result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the operand pairs where the variants disagree. These are mostly non-BCD nibbles, where the early and late low-digit corrections of the subtraction diverge, and sums where the binary zero test and the corrected zero test differ (0x99 + 0x01). No hand-picked list covers these reliably. The stimulus therefore sweeps all 256 × 256 operand pairs under both carry-in values and both operations, and drives the same inputs to one instance of each variant at once. Each output is compared against an independent model of the nibble sequence. Directed cases that pin known decimal values and flag-source differences come before the sweep.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

   // processor generation selected by the VARIANT parameter
   localparam int unsigned VAR_NMOS = 0;
   localparam int unsigned VAR_CMOS = 1;
   localparam int unsigned VAR_WIDE = 2;
   localparam int unsigned VAR_COUNT = 3;

   // default digit width (one nibble per decimal digit)
   localparam int unsigned DEF_DIGIT_W = 4;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } flags_t;

endpackage

// File: rtl/bcd_add_stage.sv
module bcd_add_stage #(
   parameter int unsigned DIGIT_W = 4
) (
   input  logic [2*DIGIT_W-1:0] a,
   input  logic [2*DIGIT_W-1:0] b,
   input  logic                 cin,
   output logic [2*DIGIT_W-1:0] mid,
   output logic                 mid_ovf,
   output logic [2*DIGIT_W-1:0] sum_out,
   output logic                 c_out
);
   localparam int unsigned BYTE_W = 2 * DIGIT_W;
   localparam int unsigned MSB = BYTE_W - 1;
   localparam logic [DIGIT_W:0]   LO_LIMIT = (DIGIT_W + 1)'(10);
   localparam logic [DIGIT_W-1:0] LO_ADJ   = DIGIT_W'((1 << DIGIT_W) - 10);
   localparam logic [BYTE_W-1:0]  HI_LIMIT = BYTE_W'(10 << DIGIT_W);
   localparam logic [BYTE_W-1:0]  HI_ADJ   = BYTE_W'(((1 << DIGIT_W) - 10) << DIGIT_W);
   localparam logic [BYTE_W:0]    HALF     = (BYTE_W + 1)'(1 << DIGIT_W);

   logic [DIGIT_W:0]   lo_raw;
   logic               lo_hit;
   logic [DIGIT_W-1:0] lo_fix;
   logic [BYTE_W:0]    hi_raw;
   logic               hi_fix;

   always_comb begin
      lo_raw = {1'b0, a[DIGIT_W-1:0]} + {1'b0, b[DIGIT_W-1:0]} + {{DIGIT_W{1'b0}}, cin};
      lo_hit = (lo_raw >= LO_LIMIT);
      lo_fix = lo_hit ? (lo_raw[DIGIT_W-1:0] + LO_ADJ) : lo_raw[DIGIT_W-1:0];
   end

   always_comb begin
      hi_raw  = {1'b0, a[MSB:DIGIT_W], lo_fix}
              + {1'b0, b[MSB:DIGIT_W], {DIGIT_W{1'b0}}}
              + (lo_hit ? HALF : '0);
      mid     = hi_raw[MSB:0];
      mid_ovf = (a[MSB] == b[MSB]) && (mid[MSB] != a[MSB]);
      hi_fix  = hi_raw[BYTE_W] || (mid >= HI_LIMIT);
      sum_out = hi_fix ? (mid + HI_ADJ) : mid;
      c_out   = hi_fix;
   end

endmodule

// File: rtl/bcd_sub_stage.sv
module bcd_sub_stage #(
   parameter int unsigned DIGIT_W = 4,
   parameter bit          LATE_LO = 1'b0
) (
   input  logic [2*DIGIT_W-1:0] a,
   input  logic [2*DIGIT_W-1:0] b,
   input  logic                 cin,
   output logic [2*DIGIT_W-1:0] diff_out
);
   localparam int unsigned BYTE_W = 2 * DIGIT_W;
   localparam int unsigned MSB = BYTE_W - 1;
   localparam logic [DIGIT_W-1:0] LO_ADJ  = DIGIT_W'((1 << DIGIT_W) - 10);
   localparam logic [BYTE_W-1:0]  LO_ADJB = BYTE_W'((1 << DIGIT_W) - 10);
   localparam logic [BYTE_W-1:0]  HI_ADJ  = BYTE_W'(((1 << DIGIT_W) - 10) << DIGIT_W);
   localparam logic [BYTE_W:0]    HALF    = (BYTE_W + 1)'(1 << DIGIT_W);

   logic [DIGIT_W:0]   lo_raw;
   logic               lo_brw;
   logic [DIGIT_W-1:0] lo_fix;
   logic [BYTE_W:0]    hi_raw;
   logic               hi_brw;
   logic [BYTE_W-1:0]  stage2;

   always_comb begin
      lo_raw = {1'b0, a[DIGIT_W-1:0]} - {1'b0, b[DIGIT_W-1:0]} - {{DIGIT_W{1'b0}}, ~cin};
      lo_brw = lo_raw[DIGIT_W];
   end

   generate
      if (LATE_LO) begin : g_late
         // low digit left raw; correction applied to the whole byte at the end
         always_comb lo_fix = lo_raw[DIGIT_W-1:0];
      end else begin : g_early
         always_comb lo_fix = lo_brw ? (lo_raw[DIGIT_W-1:0] - LO_ADJ) : lo_raw[DIGIT_W-1:0];
      end
   endgenerate

   always_comb begin
      hi_raw = {1'b0, a[MSB:DIGIT_W], lo_fix}
             - {1'b0, b[MSB:DIGIT_W], {DIGIT_W{1'b0}}}
             - (lo_brw ? HALF : '0);
      hi_brw = hi_raw[BYTE_W];
      stage2 = hi_brw ? (hi_raw[MSB:0] - HI_ADJ) : hi_raw[MSB:0];
   end

   generate
      if (LATE_LO) begin : g_late_out
         always_comb diff_out = lo_brw ? (stage2 - LO_ADJB) : stage2;
      end else begin : g_early_out
         always_comb diff_out = stage2;
      end
   endgenerate

endmodule

// File: rtl/bcd_bin_flags.sv
module bcd_bin_flags #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   input  logic              cin,
   output logic              add_zero,
   output logic [BYTE_W-1:0] sub_res,
   output logic              sub_c,
   output logic              sub_v
);
   localparam int unsigned MSB = BYTE_W - 1;

   logic [BYTE_W:0] add_raw;
   logic [BYTE_W:0] sub_raw;

   always_comb begin
      add_raw  = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
      add_zero = (add_raw[MSB:0] == '0);
      sub_raw  = {1'b0, a} - {1'b0, b} - {{BYTE_W{1'b0}}, ~cin};
      sub_res  = sub_raw[MSB:0];
      sub_c    = ~sub_raw[BYTE_W];
      sub_v    = (a[MSB] != b[MSB]) && (sub_res[MSB] != a[MSB]);
   end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu #(
   parameter int unsigned VARIANT = bcd_alu_pkg::VAR_NMOS,
   parameter int unsigned DIGIT_W = bcd_alu_pkg::DEF_DIGIT_W
) (
   input  logic [2*DIGIT_W-1:0] opnd_a,
   input  logic [2*DIGIT_W-1:0] opnd_b,
   input  logic                 carry_in,
   input  logic                 do_sub,
   output logic [2*DIGIT_W-1:0] result,
   output logic                 flag_n,
   output logic                 flag_v,
   output logic                 flag_z,
   output logic                 flag_c
);
   import bcd_alu_pkg::*;

   localparam int unsigned BYTE_W = 2 * DIGIT_W;
   localparam int unsigned MSB = BYTE_W - 1;
   localparam bit LATE_LO = (VARIANT == VAR_CMOS);

   generate
      if (VARIANT >= VAR_COUNT) begin : g_bad_variant
         $error("bcd_alu: VARIANT must be 0, 1 or 2");
      end
      if (DIGIT_W < 4) begin : g_bad_digit
         $error("bcd_alu: DIGIT_W must be at least 4");
      end
   endgenerate

   logic [MSB:0] add_mid;
   logic         add_mid_ovf;
   logic [MSB:0] add_sum;
   logic         add_c;
   logic [MSB:0] sub_diff;
   logic         bin_add_zero;
   logic [MSB:0] bin_sub_res;
   logic         bin_sub_c;
   logic         bin_sub_v;

   flags_t add_flags;
   flags_t sub_flags;

   bcd_add_stage #(.DIGIT_W(DIGIT_W)) u_add (
      .a       (opnd_a),
      .b       (opnd_b),
      .cin     (carry_in),
      .mid     (add_mid),
      .mid_ovf (add_mid_ovf),
      .sum_out (add_sum),
      .c_out   (add_c)
   );

   bcd_sub_stage #(.DIGIT_W(DIGIT_W), .LATE_LO(LATE_LO)) u_sub (
      .a        (opnd_a),
      .b        (opnd_b),
      .cin      (carry_in),
      .diff_out (sub_diff)
   );

   bcd_bin_flags #(.BYTE_W(BYTE_W)) u_bin (
      .a        (opnd_a),
      .b        (opnd_b),
      .cin      (carry_in),
      .add_zero (bin_add_zero),
      .sub_res  (bin_sub_res),
      .sub_c    (bin_sub_c),
      .sub_v    (bin_sub_v)
   );

   generate
      if (VARIANT == VAR_NMOS) begin : g_flags_nmos
         always_comb begin
            add_flags.n = add_mid[MSB];
            add_flags.v = add_mid_ovf;
            add_flags.z = bin_add_zero;
            add_flags.c = add_c;
            sub_flags.n = bin_sub_res[MSB];
            sub_flags.v = bin_sub_v;
            sub_flags.z = (bin_sub_res == '0);
            sub_flags.c = bin_sub_c;
         end
      end else begin : g_flags_late
         always_comb begin
            add_flags.n = add_sum[MSB];
            add_flags.v = add_mid_ovf;
            add_flags.z = (add_sum == '0);
            add_flags.c = add_c;
            sub_flags.n = sub_diff[MSB];
            sub_flags.v = bin_sub_v;
            sub_flags.z = (sub_diff == '0);
            sub_flags.c = bin_sub_c;
         end
      end
   endgenerate

   always_comb begin
      if (do_sub) begin
         result = sub_diff;
         {flag_n, flag_v, flag_z, flag_c} = sub_flags;
      end else begin
         result = add_sum;
         {flag_n, flag_v, flag_z, flag_c} = add_flags;
      end
   end

endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk #(
   parameter int unsigned VARIANT = 0
) (
   input logic [7:0] opnd_a,
   input logic [7:0] opnd_b,
   input logic       carry_in,
   input logic       do_sub,
   input logic [7:0] result,
   input logic       flag_n,
   input logic       flag_v,
   input logic       flag_z,
   input logic       flag_c
);
   logic a_ok, b_ok, r_ok;
   int   av, bv, rv, dsum, ddif;
   logic [8:0] bdif;

   always_comb begin
      a_ok = (opnd_a[3:0] < 4'd10) && (opnd_a[7:4] < 4'd10);
      b_ok = (opnd_b[3:0] < 4'd10) && (opnd_b[7:4] < 4'd10);
      r_ok = (result[3:0] < 4'd10) && (result[7:4] < 4'd10);
      av   = 10 * int'(opnd_a[7:4]) + int'(opnd_a[3:0]);
      bv   = 10 * int'(opnd_b[7:4]) + int'(opnd_b[3:0]);
      rv   = 10 * int'(result[7:4]) + int'(result[3:0]);
      dsum = av + bv + int'(carry_in);
      ddif = av - bv - int'(!carry_in);
      bdif = {1'b0, opnd_a} - {1'b0, opnd_b} - {8'd0, !carry_in};
   end

   always_comb begin
      AST_NO_UNKNOWN: assert (!$isunknown({result, flag_n, flag_v, flag_z, flag_c})); // R10
      if (!do_sub && a_ok && b_ok) begin
         AST_ADD_DECIMAL: assert (r_ok && rv == (dsum % 100)); // R1
         AST_ADD_CARRY: assert (flag_c == (dsum >= 100)); // R2
      end
      if (do_sub && a_ok && b_ok) begin
         if (VARIANT == 1) begin
            AST_SUB_DECIMAL_LATE: assert (r_ok && rv == ((ddif + 100) % 100)); // R6
         end else begin
            AST_SUB_DECIMAL_EARLY: assert (r_ok && rv == ((ddif + 100) % 100)); // R5
         end
      end
      if (do_sub) begin
         AST_SUB_CARRY_BIN: assert (flag_c == !bdif[8]); // R9
         if (VARIANT == 0) begin
            AST_SUB_FLAGS_BIN: assert (flag_n == bdif[7] && flag_z == (bdif[7:0] == 8'd0)); // R7
         end else begin
            AST_SUB_NZ_FINAL: assert (flag_n == result[7] && flag_z == (result == 8'd0)); // R8
         end
      end
      if (!do_sub && VARIANT != 0) begin
         AST_ADD_NZ_FINAL: assert (flag_n == result[7] && flag_z == (result == 8'd0)); // R4
      end
      if (!do_sub && VARIANT == 0) begin
         AST_ADD_Z_BIN: assert (flag_z == ((opnd_a + opnd_b + {7'd0, carry_in}) == 8'd0)); // R3
      end
   end

endmodule

bind bcd_alu bcd_alu_chk #(.VARIANT(VARIANT)) u_chk (
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .carry_in (carry_in),
   .do_sub   (do_sub),
   .result   (result),
   .flag_n   (flag_n),
   .flag_v   (flag_v),
   .flag_z   (flag_z),
   .flag_c   (flag_c)
);

// File: tb/sim_bcd_alu.sv
`timescale 1ns/100ps
module sim_bcd_alu;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [7:0] a_in, b_in;
   logic       cin_in, sub_in;
   logic [7:0] res_q [3];
   logic [3:0] flg_q [3];

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   bcd_alu #(.VARIANT(0)) u0 (
      .opnd_a(a_in), .opnd_b(b_in), .carry_in(cin_in), .do_sub(sub_in),
      .result(res_q[0]), .flag_n(flg_q[0][3]), .flag_v(flg_q[0][2]),
      .flag_z(flg_q[0][1]), .flag_c(flg_q[0][0]));
   bcd_alu #(.VARIANT(1)) u1 (
      .opnd_a(a_in), .opnd_b(b_in), .carry_in(cin_in), .do_sub(sub_in),
      .result(res_q[1]), .flag_n(flg_q[1][3]), .flag_v(flg_q[1][2]),
      .flag_z(flg_q[1][1]), .flag_c(flg_q[1][0]));
   bcd_alu #(.VARIANT(2)) u2 (
      .opnd_a(a_in), .opnd_b(b_in), .carry_in(cin_in), .do_sub(sub_in),
      .result(res_q[2]), .flag_n(flg_q[2][3]), .flag_v(flg_q[2][2]),
      .flag_z(flg_q[2][1]), .flag_c(flg_q[2][0]));

   // independent model: returns {result, N, V, Z, C}
   function automatic logic [11:0] model(int vr, int a, int b, int c, int s);
      int lo, lf, hi, mid, res, bd, bres;
      bit h, fx, lb, hb, n, v, z, cy;
      if (s == 0) begin
         lo  = (a & 15) + (b & 15) + c;
         h   = (lo >= 10);
         lf  = h ? ((lo + 6) & 15) : lo;
         hi  = ((a & 240) | lf) + (b & 240) + (h ? 16 : 0);
         mid = hi & 255;
         fx  = (hi > 255) || (mid >= 160);
         res = fx ? ((mid + 96) & 255) : mid;
         cy  = fx;
         v   = (((a ^ mid) & (b ^ mid) & 128) != 0);
         if (vr == 0) begin
            n = (mid >= 128);
            z = (((a + b + c) & 255) == 0);
         end else begin
            n = (res >= 128);
            z = (res == 0);
         end
      end else begin
         bd   = a - b - (1 - c);
         bres = bd & 255;
         cy   = (bd >= 0);
         v    = (((a ^ b) & (a ^ bres) & 128) != 0);
         lo   = (a & 15) - (b & 15) - (1 - c);
         lb   = (lo < 0);
         if (vr == 1) lf = lo & 15;
         else         lf = lb ? ((lo - 6) & 15) : (lo & 15);
         hi   = ((a & 240) | lf) - (b & 240) - (lb ? 16 : 0);
         hb   = (hi < 0);
         res  = (hb ? (hi - 96) : hi) & 255;
         if (vr == 1 && lb) res = (res - 6) & 255;
         if (vr == 0) begin
            n = (bres >= 128);
            z = (bres == 0);
         end else begin
            n = (res >= 128);
            z = (res == 0);
         end
      end
      return {res[7:0], n, v, z, cy};
   endfunction

   task automatic chk(string tag, int vr, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s variant=%0d a=%02h b=%02h cin=%0d sub=%0d actual=%0h expected=%0h",
                  tag, vr, a_in, b_in, cin_in, sub_in, act, exp);
      end
   endtask

   task automatic apply(int a, int b, int c, int s);
      a_in   = a[7:0];
      b_in   = b[7:0];
      cin_in = c[0];
      sub_in = s[0];
      #1;
   endtask

   // quiet inputs: 0 + 0 without carry gives 0 with only Z set
   task automatic t_idle();
      apply(0, 0, 0, 0);
      for (int vr = 0; vr < 3; vr++) begin
         chk("R1 idle result", vr, res_q[vr], 0);
         chk("R4 idle flags", vr, flg_q[vr], 4'b0010);
      end
      #1;
   endtask

   task automatic t_add_digits();
      apply(8'h58, 8'h46, 1, 0);            // 58+46+1 = 105
      for (int vr = 0; vr < 3; vr++) begin
         chk("R1 add digits", vr, res_q[vr], 8'h05);
         chk("R2 add carry out", vr, flg_q[vr][0], 1);
      end
      #1;
      apply(8'h15, 8'h26, 0, 0);            // 41, no carry
      for (int vr = 0; vr < 3; vr++) begin
         chk("R1 add low adjust", vr, res_q[vr], 8'h41);
         chk("R2 add no carry", vr, flg_q[vr][0], 0);
      end
      #1;
   endtask

   task automatic t_add_flag_source();
      apply(8'h99, 8'h01, 0, 0);            // high stage 0xA0, final 0x00
      chk("R3 nmos add result", 0, res_q[0], 8'h00);
      chk("R3 nmos add N from mid", 0, flg_q[0][3], 1);
      chk("R3 nmos add Z from binary", 0, flg_q[0][1], 0);
      chk("R4 cmos add N final", 1, flg_q[1][3], 0);
      chk("R4 cmos add Z final", 1, flg_q[1][1], 1);
      chk("R4 wide add Z final", 2, flg_q[2][1], 1);
      chk("R4 add V", 1, flg_q[1][2], 0);
      #1;
      apply(8'h50, 8'h50, 0, 0);            // mid 0xA0 sign flip from 0: V=1
      for (int vr = 0; vr < 3; vr++) chk("R4 add V overflow", vr, flg_q[vr][2], 1);
      #1;
   endtask

   task automatic t_sub_borrow();
      apply(8'h12, 8'h21, 1, 1);            // 12-21 -> 91 with borrow
      for (int vr = 0; vr < 3; vr++) begin
         chk("R5 R6 sub borrow result", vr, res_q[vr], 8'h91);
         chk("R8 sub C binary", vr, flg_q[vr][0], 0);
         chk("R7 sub N", vr, flg_q[vr][3], 1);
      end
      #1;
      apply(8'h50, 8'h25, 0, 1);            // borrow in: 50-25-1 = 24
      for (int vr = 0; vr < 3; vr++) begin
         chk("R9 sub borrow in", vr, res_q[vr], 8'h24);
         chk("R9 sub no borrow out", vr, flg_q[vr][0], 1);
      end
      #1;
      apply(8'h50, 8'h25, 1, 1);
      for (int vr = 0; vr < 3; vr++) chk("R9 sub carry set", vr, res_q[vr], 8'h25);
      #1;
   endtask

   task automatic t_sweep();
      logic [11:0] e;
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++)
               for (int b = 0; b < 256; b++) begin
                  apply(a, b, c, s);
                  for (int vr = 0; vr < 3; vr++) begin
                     e = model(vr, a, b, c, s);
                     if (s == 0) begin
                        chk("R2 R10 sweep add result", vr, res_q[vr], e[11:4]);
                        chk(vr == 0 ? "R3 sweep add flags" : "R4 sweep add flags",
                            vr, flg_q[vr], e[3:0]);
                     end else begin
                        chk(vr == 1 ? "R6 sweep sub result" : "R5 sweep sub result",
                            vr, res_q[vr], e[11:4]);
                        chk(vr == 0 ? "R7 sweep sub flags" : "R8 sweep sub flags",
                            vr, flg_q[vr], e[3:0]);
                     end
                  end
                  #1;
               end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      a_in = 8'h00; b_in = 8'h00; cin_in = 1'b0; sub_in = 1'b0;
      #3;
      t_idle();
      t_add_digits();
      t_add_flag_source();
      t_sub_borrow();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule